// File: doc/BRIEF.md
# Single-Location Load Order Monitor

This block is a runtime checker that sits beside a memory system and watches the completed operations of two agents on one shared location. One agent, the producer, stores the values 1, 2, 3 and onward, one step at a time. The other agent, the observer, loads the location again and again. Under a coherent memory, the observer can never see the location go backwards. It also cannot see a value that the producer has not stored yet.

The monitor keeps the highest value the observer has loaded so far. It also counts the producer's stores, and that count is the highest value produced so far. The location starts at 0. A load that returns a smaller value than an earlier load is an error. So is a load that returns more than the store count. On the first error the monitor raises a sticky flag and captures the earlier and later values of the offending pair. The flag stays set until a synchronous reset. The block checks ordering only: it does not model the memory, and it does not check the data that is stored.

Top module: `coh_order_mon`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `err` is 0 and `err_prev` and `err_curr` are 0.
- R2: An observer load (`op_agent`=1, `op_write`=0) that returns a value below an earlier observer load sets `err` on the clock edge that accepts it. For example, loads 1,3,2 after three stores, or loads 1 then 0.
- R3: Observer loads that never decrease and never exceed the store count do not set `err`. This includes repeated equal values and a load of 0 before any store.
- R4: An observer load that returns a value above the number of producer stores accepted so far sets `err`.
- R5: Once set, `err` stays 1 until `rst` is asserted, whatever operations follow.
- R6: On the first violation only, `err_prev` takes the highest earlier observer value and `err_curr` takes the offending value. Later violations leave both unchanged.
- R7: Each producer store (`op_agent`=0, `op_write`=1) advances the store count by exactly one, whatever its `op_data` carries.
- R8: Observer stores and producer loads have no effect on the store count, on the observer history or on `err`.
- R9: The store count saturates at 2^DW-1 and never wraps. After any number of stores, a load of 2^DW-1 is legal and a later smaller load is still flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | One completed operation this cycle |
| op_agent | input | 1 | 0 = producer, 1 = observer |
| op_write | input | 1 | 1 = store, 0 = load |
| op_data | input | DW | Value stored or value returned by the load |
| err | output | 1 | Sticky ordering violation flag |
| err_prev | output | DW | Earlier value of the first offending pair |
| err_curr | output | DW | Later value of the first offending pair |

## Verification
The bench goes after a backward step that follows a jump, as in 1,3,2. A design that compared a load only with the store count, or only with the load just before it, would miss that case or would latch the wrong pair. A load of 0 at the start and repeated equal loads must stay silent; a design with a strict comparison would raise a false error on them. The bench also runs the store count past its maximum at a small width, where a design whose counter wraps would flag a legal load or would let a true backward step go unflagged. Observer stores and producer loads with large data are mixed into the random traffic. A design that decoded the agent or the operation type wrongly would move its history and raise errors that do not exist.

// File: rtl/coh_order_mon.sv
module coh_order_mon #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic          op_agent,
  input  logic          op_write,
  input  logic [DW-1:0] op_data,
  output logic          err,
  output logic [DW-1:0] err_prev,
  output logic [DW-1:0] err_curr
);
  localparam logic [DW-1:0] MAXV = {DW{1'b1}};

  logic [DW-1:0] cnt, last;

  wire ld_ev = op_valid & op_agent & ~op_write;
  wire st_ev = op_valid & ~op_agent & op_write;
  wire back  = ld_ev & (op_data < last);
  wire ahead = ld_ev & (op_data > cnt);
  wire viol  = back | ahead;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      last     <= '0;
      err      <= 1'b0;
      err_prev <= '0;
      err_curr <= '0;
    end else begin
      if (st_ev && cnt != MAXV) cnt <= cnt + 1'b1;
      if (ld_ev && !back) last <= op_data;
      if (viol && !err) begin
        err      <= 1'b1;
        err_prev <= last;
        err_curr <= op_data;
      end
    end
  end

  p_backward_r2: assert property (@(posedge clk) disable iff (rst)
    (ld_ev && op_data < last) |=> err);

  p_ahead_r4: assert property (@(posedge clk) disable iff (rst)
    (ld_ev && op_data > cnt) |=> err);

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  p_pair_hold_r6: assert property (@(posedge clk) disable iff (rst)
    err |=> ($stable(err_prev) && $stable(err_curr)));

  p_count_mono_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt >= $past(cnt));

  p_history_mono_r8: assert property (@(posedge clk) disable iff (rst)
    !ld_ev |=> $stable(last));
endmodule

// File: tb/coh_order_mon_test.sv
module coh_order_mon_test;
  localparam int CLK_T = 10;
  localparam int DW = 4;
  localparam int MAXV = (1 << DW) - 1;

  logic clk = 0, rst = 1, op_valid = 0, op_agent = 0, op_write = 0;
  logic [DW-1:0] op_data = '0;
  logic err;
  logic [DW-1:0] err_prev, err_curr;

  int n_chk = 0, n_fail = 0;
  int m_cnt, m_last, m_prev, m_curr;
  bit m_err;

  always #(CLK_T/2) clk = ~clk;

  coh_order_mon #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_agent(op_agent),
    .op_write(op_write), .op_data(op_data),
    .err(err), .err_prev(err_prev), .err_curr(err_curr));

  function automatic bit is_viol(int last, int cnt, int d);
    return (d < last) || (d > cnt);
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (err !== m_err || err_prev !== m_prev[DW-1:0] || err_curr !== m_curr[DW-1:0]) begin
      n_fail++;
      $display("FAIL %s: got err=%0b prev=%0d curr=%0d expected err=%0b prev=%0d curr=%0d",
               tag, err, err_prev, err_curr, m_err, m_prev, m_curr);
    end
  endtask

  task automatic do_reset();
    rst = 1; op_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    m_cnt = 0; m_last = 0; m_err = 0; m_prev = 0; m_curr = 0;
    @(negedge clk);
    check("R1 reset state");
  endtask

  task automatic op(bit agent, bit wr, int d, string tag);
    op_valid = 1; op_agent = agent; op_write = wr; op_data = d[DW-1:0];
    @(negedge clk);
    op_valid = 0;
    if (!agent && wr) begin
      if (m_cnt != MAXV) m_cnt++;
    end else if (agent && !wr) begin
      if (is_viol(m_last, m_cnt, d) && !m_err) begin
        m_err = 1; m_prev = m_last; m_curr = d;
      end
      if (d >= m_last) m_last = d;
    end
    check(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    do_reset();

    op(1, 0, 0, "R3 zero before any store");
    for (int i = 1; i <= 3; i++) op(0, 1, 9, "R7 store data ignored");
    op(1, 0, 1, "R3 load 1");
    op(1, 0, 3, "R3 load 3");
    op(1, 0, 3, "R3 repeated load");
    op(1, 0, 2, "R2 load 1,3,2 backward");
    op(1, 0, 1, "R6 pair held on second violation");
    op(0, 1, 0, "R5 sticky after store");
    op(1, 0, 3, "R5 sticky after legal load");

    do_reset();
    op(0, 1, 1, "R7 store");
    op(1, 0, 1, "R3 load 1");
    op(1, 0, 0, "R2 load 1 then 0");

    do_reset();
    op(0, 1, 1, "R7 store");
    op(1, 0, 2, "R4 load beyond store count");

    do_reset();
    op(1, 1, 5, "R8 observer store");
    op(1, 0, 1, "R8 observer store does not count");

    do_reset();
    op(0, 1, 1, "R7 store");
    op(0, 1, 2, "R7 store");
    op(1, 0, 2, "R3 load 2");
    op(0, 0, 0, "R8 producer load");
    op(1, 0, 2, "R8 producer load leaves history");

    do_reset();
    for (int i = 0; i < MAXV + 6; i++) op(0, 1, i, "R9 store past max");
    op(1, 0, MAXV, "R9 max value legal after saturation");
    op(1, 0, MAXV - 1, "R9 backward step after saturation");

    for (int t = 0; t < 300; t++) begin
      do_reset();
      for (int k = 0; k < 40; k++) begin
        int sel = $urandom_range(0, 9);
        if (sel < 3) op(0, 1, $urandom_range(0, MAXV), "R7 random store");
        else if (sel == 3) op(1, 1, $urandom_range(0, MAXV), "R8 random observer store");
        else if (sel == 4) op(0, 0, $urandom_range(0, MAXV), "R8 random producer load");
        else if (sel < 9) op(1, 0, $urandom_range(m_last, m_cnt), "R3 random legal load");
        else op(1, 0, $urandom_range(0, MAXV), "R2 R4 R6 random load");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule